// File: doc/BRIEF.md
# Translation Cache with Contiguous-Range Entries

This block is a small, fully associative cache of address translations for 4KB base pages. Its lookup port takes a virtual page number and, one cycle later, reports a hit or a miss together with the physical page number and attribute bits. Its fill port writes a new translation into the next slot in round-robin order.

A page-table entry may carry a contiguous hint. When the hint is set and hint use is enabled, the filled slot stands for an aligned run of sixteen base pages, which is 64KB. Lookups into such a slot ignore the low four bits of the virtual page number and pass those bits through into the physical page number. The block trusts that the sixteen page-table entries of such a run agree, and it never fetches the other fifteen. When hint use is disabled, every fill makes a single-page slot, and translations stay correct.

A flush input empties the whole table in one cycle. Page-table walking, permission checks and address-space tags are left to the surrounding logic.

Top module: `rtlb_cache`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `lk_req` high, and low in the cycle after each cycle with `lk_req` low. `rsp_hit`, `rsp_ppn` and `rsp_attr` are updated only when a request was made.
- R2: A single-page slot hits only for exactly the virtual page number it was filled with. It returns the filled frame number and attributes unchanged.
- R3: A fill with `fill_contig`=1 while `hint_en`=1 makes a slot that hits for all sixteen page numbers sharing bits [VPN_W-1:4] with `fill_vpn`. Its result is `fill_pfn` with bits [3:0] replaced by the lookup's `lk_vpn[3:0]`. Page numbers outside that aligned run miss.
- R4: With `hint_en`=0, `fill_contig` has no effect. The fill makes a single-page slot, so a neighbouring page in the same 64KB run misses.
- R5: On a miss, `rsp_hit`=0, `rsp_ppn`=0 and `rsp_attr`=0.
- R6: The table has 16 slots, written in round-robin order starting at slot 0. The 17th fill after a reset or flush overwrites the translation written by the 1st.
- R7: When several slots match, the lowest-numbered slot supplies the result.
- R8: `flush` empties every slot in one cycle and returns the fill order to slot 0. A fill presented in the same cycle as `flush` is dropped.
- R9: A lookup in the same cycle as a fill or flush sees the table as it was before that fill or flush.
- R10: After reset, `rsp_valid` is 0 and every lookup misses until a fill is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hint_en | input | 1 | Allow the contiguous hint to make 64KB slots |
| flush | input | 1 | Empty the whole table |
| fill_en | input | 1 | Write a translation this cycle |
| fill_vpn | input | VPN_W | Virtual page number for the fill |
| fill_pfn | input | PPN_W | Physical frame number from the page-table entry |
| fill_attr | input | ATTR_W | Attribute bits from the page-table entry |
| fill_contig | input | 1 | Contiguous hint bit from the page-table entry |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | PPN_W | Translated physical page number |
| rsp_attr | output | ATTR_W | Attributes of the translation |

## Verification
The bench fills contiguous slots with frame numbers whose low four bits are non-zero. A design that kept those bits, or that failed to merge in the lookup's low bits, returns wrong frames on some of the sixteen pages. Overlapping plain and contiguous slots are placed in both index orders to expose a wrong priority. Fills are made with the hint set but disabled, to catch a design that still widens the slot. Fills and flushes land in the same cycle as lookups to catch a forwarded or a dropped state. A run of seventeen fills, and a flush that carries a fill, show whether the replacement order and the flush reset the pointer as required.

// File: rtl/rtlb_pkg.sv
package rtlb_pkg;
  localparam int unsigned DEF_VPN_W     = 20;
  localparam int unsigned DEF_PPN_W     = 20;
  localparam int unsigned DEF_ATTR_W    = 4;
  localparam int unsigned DEF_ENTRIES   = 16;
  localparam int unsigned DEF_SPAN_LOG2 = 4;
endpackage

// File: rtl/rtlb_match.sv
module rtlb_match #(
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned SPAN_LOG2 = 4
) (
  input  logic             valid,
  input  logic             contig,
  input  logic [VPN_W-1:0] vtag,
  input  logic [VPN_W-1:0] vpn,
  output logic             hit
);
  localparam logic [VPN_W-1:0] LOW_MASK =
    {{(VPN_W-SPAN_LOG2){1'b0}}, {SPAN_LOG2{1'b1}}};

  logic [VPN_W-1:0] cmp_mask;

  always_comb begin
    cmp_mask = contig ? ~LOW_MASK : '1;
    hit      = valid && (((vtag ^ vpn) & cmp_mask) == '0);
  end
endmodule

// File: rtl/rtlb_prio.sv
module rtlb_prio #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] sel,
  output logic         any
);
  logic found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/rtlb_rr.sv
module rtlb_rr #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (clr)    ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/rtlb_cache.sv
module rtlb_cache
  import rtlb_pkg::*;
#(
  parameter int unsigned VPN_W     = DEF_VPN_W,
  parameter int unsigned PPN_W     = DEF_PPN_W,
  parameter int unsigned ATTR_W    = DEF_ATTR_W,
  parameter int unsigned ENTRIES   = DEF_ENTRIES,
  parameter int unsigned SPAN_LOG2 = DEF_SPAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hint_en,
  input  logic              flush,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_pfn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic              fill_contig,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [ATTR_W-1:0] rsp_attr
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [VPN_W-1:0] VLOW =
    {{(VPN_W-SPAN_LOG2){1'b0}}, {SPAN_LOG2{1'b1}}};
  localparam logic [PPN_W-1:0] PLOW =
    {{(PPN_W-SPAN_LOG2){1'b0}}, {SPAN_LOG2{1'b1}}};

  // Tag stored for a slot: low span bits cleared for a contiguous slot.
  function automatic logic [VPN_W-1:0] tag_of(input logic [VPN_W-1:0] vpn,
                                               input logic contig);
    return contig ? (vpn & ~VLOW) : vpn;
  endfunction

  // Frame stored for a slot: aligned base for a contiguous slot.
  function automatic logic [PPN_W-1:0] base_of(input logic [PPN_W-1:0] pfn,
                                                input logic contig);
    return contig ? (pfn & ~PLOW) : pfn;
  endfunction

  // Output frame: a contiguous slot passes the page offset within its run.
  function automatic logic [PPN_W-1:0] xlate(input logic [PPN_W-1:0] base,
                                              input logic contig,
                                              input logic [VPN_W-1:0] vpn);
    return contig ? (base | (PPN_W'(vpn & VLOW) & PLOW)) : base;
  endfunction

  // Table state
  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_contig;
  logic [VPN_W-1:0]   ent_vtag [ENTRIES];
  logic [PPN_W-1:0]   ent_pfn  [ENTRIES];
  logic [ATTR_W-1:0]  ent_attr [ENTRIES];

  // Named events
  logic               fill_fire;
  logic               eff_contig;
  logic [IDX_W-1:0]   fill_ptr;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] sel_vec;
  logic               hit_any;
  logic [PPN_W-1:0]   sel_ppn;
  logic [ATTR_W-1:0]  sel_attr;

  assign fill_fire  = fill_en & ~flush;
  assign eff_contig = fill_contig & hint_en;

  rtlb_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (fill_fire),
    .clr  (flush),
    .ptr  (fill_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      ent_contig <= '0;
    end else if (flush) begin
      ent_valid  <= '0;
    end else if (fill_fire) begin
      ent_valid[fill_ptr]  <= 1'b1;
      ent_contig[fill_ptr] <= eff_contig;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) begin
      ent_vtag[fill_ptr] <= tag_of(fill_vpn, eff_contig);
      ent_pfn[fill_ptr]  <= base_of(fill_pfn, eff_contig);
      ent_attr[fill_ptr] <= fill_attr;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    rtlb_match #(.VPN_W(VPN_W), .SPAN_LOG2(SPAN_LOG2)) u_match (
      .valid (ent_valid[g]),
      .contig(ent_contig[g]),
      .vtag  (ent_vtag[g]),
      .vpn   (lk_vpn),
      .hit   (match_vec[g])
    );
  end

  rtlb_prio #(.N(ENTRIES)) u_prio (
    .req(match_vec),
    .sel(sel_vec),
    .any(hit_any)
  );

  always_comb begin
    sel_ppn  = '0;
    sel_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel_vec[i]) begin
        sel_ppn  = sel_ppn  | xlate(ent_pfn[i], ent_contig[i], lk_vpn);
        sel_attr = sel_attr | ent_attr[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_attr  <= '0;
    end else begin
      rsp_valid <= lk_req;
      if (lk_req) begin
        rsp_hit  <= hit_any;
        rsp_ppn  <= sel_ppn;
        rsp_attr <= sel_attr;
      end
    end
  end
endmodule

// File: rtl/rtlb_chk.sv
module rtlb_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned ATTR_W  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               flush,
  input logic               hint_en,
  input logic               fill_fire,
  input logic [IDX_W-1:0]   fill_ptr,
  input logic [ENTRIES-1:0] ent_valid,
  input logic [ENTRIES-1:0] ent_contig,
  input logic [ENTRIES-1:0] sel_vec,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [PPN_W-1:0]   rsp_ppn,
  input logic [ATTR_W-1:0]  rsp_attr
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid); // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid); // R1
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_attr == '0)); // R5
  AST_HINT_OFF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !hint_en) |=> !ent_contig[$past(fill_ptr)]); // R4
  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> ent_valid[$past(fill_ptr)]); // R6
  AST_PTR_ROUND_ROBIN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (fill_ptr == (($past(fill_ptr) == IDX_W'(ENTRIES - 1)) ?
                                IDX_W'(0) : IDX_W'($past(fill_ptr) + 1'b1)))); // R6
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (ent_valid == '0 && fill_ptr == '0)); // R8
endmodule

bind rtlb_cache rtlb_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .flush     (flush),
  .hint_en   (hint_en),
  .fill_fire (fill_fire),
  .fill_ptr  (fill_ptr),
  .ent_valid (ent_valid),
  .ent_contig(ent_contig),
  .sel_vec   (sel_vec),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_ppn   (rsp_ppn),
  .rsp_attr  (rsp_attr)
);

// File: tb/test_rtlb_cache.sv
`timescale 1ns/1ps
module test_rtlb_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hint_en = 1'b0;
  logic        flush = 1'b0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [3:0]  fill_attr = '0;
  logic        fill_contig = 1'b0;
  logic        lk_req = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic        rsp_valid, rsp_hit;
  logic [19:0] rsp_ppn;
  logic [3:0]  rsp_attr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtlb_cache i_rtlb_cache (
    .clk(clk), .rst_n(rst_n), .hint_en(hint_en), .flush(flush),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_attr(fill_attr), .fill_contig(fill_contig),
    .lk_req(lk_req), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr)
  );

  // Reference model of the table
  bit        m_valid [16];
  bit        m_contig[16];
  bit [19:0] m_vtag  [16];
  bit [19:0] m_pfn   [16];
  bit [3:0]  m_attr  [16];
  int        m_ptr = 0;

  // Returns {hit, ppn, attr}
  function automatic bit [24:0] model_lookup(input bit [19:0] vpn);
    for (int i = 0; i < 16; i++) begin
      if (m_valid[i]) begin
        if (m_contig[i] ? (vpn[19:4] == m_vtag[i][19:4]) : (vpn == m_vtag[i])) begin
          if (m_contig[i]) return {1'b1, m_pfn[i][19:4], vpn[3:0], m_attr[i]};
          return {1'b1, m_pfn[i], m_attr[i]};
        end
      end
    end
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: inputs driven at a falling edge, result sampled at the next.
  task automatic step(input bit fe, input bit [19:0] fv, input bit [19:0] fp,
                      input bit [3:0] fa, input bit fc, input bit fl,
                      input bit rq, input bit [19:0] rv, input string tag);
    bit [24:0] e;
    fill_en = fe; fill_vpn = fv; fill_pfn = fp; fill_attr = fa;
    fill_contig = fc; flush = fl; lk_req = rq; lk_vpn = rv;
    e = model_lookup(rv);
    if (fl) begin
      for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
      m_ptr = 0;
    end else if (fe) begin
      m_valid[m_ptr] = 1'b1; m_contig[m_ptr] = fc & hint_en;
      m_vtag[m_ptr] = fv; m_pfn[m_ptr] = fp; m_attr[m_ptr] = fa;
      m_ptr = (m_ptr + 1) % 16;
    end
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0; flush = 1'b0; lk_req = 1'b0;
    if (rq) chk(tag, {38'd0, rsp_valid, rsp_hit, rsp_ppn, rsp_attr}, {38'd0, 1'b1, e});
    else    chk(tag, {63'd0, rsp_valid}, 64'd0);
  endtask

  task automatic look(input bit [19:0] v, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, v, tag);
  endtask

  task automatic fill(input bit [19:0] v, input bit [19:0] p, input bit [3:0] a,
                      input bit c, input string tag);
    step(1, v, p, a, c, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20230706));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    look(20'h00000, "R10 empty table misses");
    look(20'h12345, "R5 miss outputs zero");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1 no request no response");

    hint_en = 1'b1;
    // R2 single-page slot
    fill(20'h12345, 20'hABCDE, 4'h5, 0, "R2 fill");
    look(20'h12345, "R2 exact hit");
    look(20'h12344, "R2 neighbour misses");
    look(20'h12355, "R2 other page misses");

    // R3 contiguous slot, frame with non-zero low bits
    fill(20'h40007, 20'h7777B, 4'h9, 1, "R3 fill");
    for (int k = 0; k < 16; k++) look(20'h40000 | k, "R3 run page");
    look(20'h40010, "R3 above run misses");
    look(20'h3FFFF, "R3 below run misses");

    // R4 hint ignored when disabled
    hint_en = 1'b0;
    fill(20'h50003, 20'h11113, 4'h3, 1, "R4 fill");
    look(20'h50003, "R4 exact hit");
    look(20'h50004, "R4 neighbour misses");
    hint_en = 1'b1;

    // R9 fill and lookup together
    step(1, 20'h60000, 20'h0F00F, 4'hC, 0, 0, 1, 20'h60000, "R9 sees pre-fill");
    look(20'h60000, "R9 visible next cycle");

    // R8 flush carrying a fill, lookup in the same cycle sees old state
    step(1, 20'h70000, 20'h01234, 4'h1, 0, 1, 1, 20'h12345, "R9 sees pre-flush");
    look(20'h70000, "R8 fill in flush cycle dropped");
    look(20'h12345, "R8 flushed entry misses");
    look(20'h40003, "R8 flushed run misses");

    // R7 priority, contiguous slot at lower index
    fill(20'h80000, 20'h22220, 4'h1, 1, "R7 fill 0");
    fill(20'h80003, 20'h33333, 4'h2, 0, "R7 fill 1");
    look(20'h80003, "R7 lower contiguous wins");
    fill(20'h90005, 20'h44444, 4'h4, 0, "R7 fill 2");
    fill(20'h90000, 20'h55550, 4'h6, 1, "R7 fill 3");
    look(20'h90005, "R7 lower plain wins");
    look(20'h90006, "R7 run covers rest");

    // R6 round robin wrap
    step(0, 0, 0, 0, 0, 1, 0, 0, "R8 flush");
    for (int k = 0; k < 16; k++)
      fill(20'hA0000 + 20'(k * 16), 20'h10000 + 20'(k), 4'(k), 0, "R6 fill");
    look(20'hA0000, "R6 first slot present");
    fill(20'hB0000, 20'hBBBBB, 4'hB, 0, "R6 17th fill");
    look(20'hA0000, "R6 oldest evicted");
    look(20'hA0010, "R6 second kept");
    look(20'hB0000, "R6 newest hit");
    look(20'hA00F0, "R6 last kept");

    // Random mix over a small page pool
    for (int n = 0; n < 4000; n++) begin
      bit fe, fl, rq, fc;
      bit [19:0] fv, rv, fp;
      if ($urandom % 64 == 0) hint_en = ~hint_en;
      fe = ($urandom % 10) < 3;
      fl = ($urandom % 50) == 0;
      rq = ($urandom % 10) < 7;
      fc = $urandom % 2;
      fv = 20'hC0000 | 20'($urandom % 64);
      rv = 20'hC0000 | 20'($urandom % 64);
      fp = 20'($urandom);
      step(fe, fv, fp, 4'($urandom), fc, fl, rq, rv, "R3 R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule